// File: doc/BRIEF.md
# Class-Level Egress Scheduler with Strict Levels, Minimum Guarantee and Weighted Excess Sharing

This block chooses which of up to eight traffic classes under one subscriber node sends its next packet. Each class reports whether its queue holds a packet and how long the head packet is. Each class also carries a small set of configuration fields: a priority code, a peak-rate shaper rate, a minimum-bandwidth rate and an excess-share ratio. On every cycle in which the downstream side asks for a decision, the scheduler looks at the service levels in a fixed order and names one class on its grant output one cycle later.

The levels are two strict-priority tiers, then classes that hold a minimum-bandwidth guarantee, then classes that share the leftover capacity. The leftover share uses deficit-weighted round robin, with a per-visit quantum that grows with the configured ratio. A peak-rate token bucket sits in front of every class, and it gates that class at every level. This keeps the strict tiers from starving everything below them. A non-priority class must choose exactly one of a minimum rate or an excess ratio. A class configured with both, or with neither, is never served.

Packet storage and the port and group levels above the subscriber are outside this block. Byte counts are abstract credit units, and one refill happens per clock cycle.

Top module: `hcs_sched`

## Requirements
- R1: After reset `grant_vld` is low. A grant appears, with `grant_vld` high and `grant_cls` naming the class, only in the cycle after a clock edge at which `pick_en` was high and some class was eligible.
- R2: Levels are served in strict order: priority-1, then priority-2, then minimum-guarantee, then excess. This holds regardless of class index.
- R3: Within the priority-1, priority-2 or minimum level, the eligible class with the lowest index wins.
- R4: The 2-bit priority code of class i sits at `cfg_prio[2i+1:2i]`. Code 01 means priority-1, 10 means priority-2, and 00 or 11 mean non-priority. A non-priority class with a nonzero minimum rate and a zero ratio is a minimum class. A non-priority class with a nonzero ratio and a zero minimum rate is an excess class.
- R5: Each class has a peak-rate token bucket. The bucket is 0 after reset and gains the class's shaper rate every cycle. It loses the packet length when the class is granted. While the bucket is negative, the class is ineligible at every level.
- R6: Any rate code (shaper or minimum) below 8 acts as 8.
- R7: A token bucket never holds more than BURST (default 512) credits.
- R8: A minimum class is served at the minimum level only while its minimum bucket is non-negative. That bucket refills at the minimum rate each cycle and is charged on each grant.
- R9: Excess classes share by deficit-weighted round robin. The quantum is ratio × 64 credits, with the ratio in the range 1 to 1020. Excess service happens only when no priority or minimum class is eligible.
- R10: A non-priority class with both a nonzero minimum rate and a nonzero ratio, or with both zero, is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pick_en | input | 1 | Request one scheduling decision this cycle |
| q_nonempty | input | N | Per-class queue holds a packet |
| q_len | input | N*LEN_W | Per-class head packet length |
| cfg_prio | input | 2*N | Per-class priority code |
| cfg_shape_rate | input | N*RATE_W | Per-class peak shaper refill per cycle |
| cfg_min_rate | input | N*RATE_W | Per-class minimum-rate refill per cycle |
| cfg_ratio | input | N*RATIO_W | Per-class excess-share ratio |
| grant_vld | output | 1 | A grant was made at the previous edge |
| grant_cls | output | $clog2(N) | Index of the granted class |

## Verification
The bench builds the block with its defaults: eight classes, 11-bit lengths, 12-bit rates, a floor of 8, a 512-credit burst cap and a quantum scale of 64. With 64-credit packets and a rate of 8, a shaped class sends exactly one packet every eight picks. That makes exact grant counts over fixed windows predictable, including the burst drained after an idle gap. Ratios of 1 and 3 with the same packet size give an exact three-to-one excess pattern.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  typedef enum logic [1:0] {
    LVL_P1  = 2'd0,
    LVL_P2  = 2'd1,
    LVL_MIN = 2'd2,
    LVL_XS  = 2'd3
  } hcs_lvl_e;

  localparam logic [1:0] PRIO_CODE_P1 = 2'b01;
  localparam logic [1:0] PRIO_CODE_P2 = 2'b10;
  localparam int         RATIO_MAX    = 1020;
endpackage

// File: rtl/hcs_bucket.sv
module hcs_bucket #(
  parameter int RATE_W     = 12,
  parameter int LEN_W      = 11,
  parameter int RATE_FLOOR = 8,
  parameter int BURST      = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              charge,
  input  logic [LEN_W-1:0]  charge_len,
  output logic              ok
);
  localparam int BKT_W = $clog2(BURST + 2**RATE_W + 2**LEN_W) + 2;

  logic signed [BKT_W-1:0] bkt_q, bkt_d, sum;
  logic [RATE_W-1:0]       eff_rate;

  always_comb begin
    eff_rate = (rate < RATE_W'(RATE_FLOOR)) ? RATE_W'(RATE_FLOOR) : rate;
    sum = bkt_q + $signed(BKT_W'(eff_rate));
    if (charge) sum = sum - $signed(BKT_W'(charge_len));
    bkt_d = (sum > $signed(BKT_W'(BURST))) ? $signed(BKT_W'(BURST)) : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bkt_q <= '0;
    else        bkt_q <= bkt_d;
  end

  assign ok = !bkt_q[BKT_W-1];

  a_r7_bucket_cap: assert property (@(posedge clk) disable iff (!rst_n)
    bkt_q <= $signed(BKT_W'(BURST)));
endmodule

// File: rtl/hcs_dwrr.sv
module hcs_dwrr #(
  parameter int N           = 8,
  parameter int LEN_W       = 11,
  parameter int RATIO_W     = 10,
  parameter int QUANT_SCALE = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           elig,
  input  logic [N-1:0]           nonempty,
  input  logic [N*LEN_W-1:0]     lens_flat,
  input  logic [N*RATIO_W-1:0]   ratio_flat,
  input  logic                   serve,
  output logic                   hit,
  output logic [$clog2(N)-1:0]   win
);
  import hcs_pkg::*;
  localparam int IDX_W = $clog2(N);
  localparam int DEF_W = $clog2(RATIO_MAX * QUANT_SCALE + 2**LEN_W) + 1;

  logic [LEN_W-1:0]   lens  [N];
  logic [RATIO_W-1:0] ratio [N];
  logic [DEF_W-1:0]   def_q [N];
  logic [DEF_W-1:0]   def_d [N];
  logic [IDX_W-1:0]   ptr_q, ptr_d, nxt;
  logic               any, cur_ok, found;
  logic [RATIO_W-1:0] rq;
  logic [DEF_W-1:0]   add;

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign lens[g]  = lens_flat[g*LEN_W +: LEN_W];
    assign ratio[g] = ratio_flat[g*RATIO_W +: RATIO_W];
  end

  always_comb begin
    any   = |elig;
    nxt   = ptr_q;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (!found && elig[idx]) begin
        nxt   = IDX_W'(idx);
        found = 1'b1;
      end
    end
    cur_ok = elig[ptr_q] && (def_q[ptr_q] >= DEF_W'(lens[ptr_q]));
    rq  = (ratio[nxt] > RATIO_W'(RATIO_MAX)) ? RATIO_W'(RATIO_MAX) : ratio[nxt];
    add = def_q[nxt] + DEF_W'(rq) * DEF_W'(QUANT_SCALE);
    hit = cur_ok || (any && (add >= DEF_W'(lens[nxt])));
    win = cur_ok ? ptr_q : nxt;
  end

  always_comb begin
    ptr_d = ptr_q;
    for (int i = 0; i < N; i++) def_d[i] = def_q[i];
    if (serve) begin
      if (cur_ok) begin
        def_d[ptr_q] = def_q[ptr_q] - DEF_W'(lens[ptr_q]);
      end else if (any) begin
        ptr_d      = nxt;
        def_d[nxt] = hit ? (add - DEF_W'(lens[nxt])) : add;
      end
    end
    for (int i = 0; i < N; i++) if (!nonempty[i]) def_d[i] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < N; i++) def_q[i] <= '0;
    end else begin
      ptr_q <= ptr_d;
      for (int i = 0; i < N; i++) def_q[i] <= def_d[i];
    end
  end

  a_r9_win_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (serve && hit) |-> elig[win]);
endmodule

// File: rtl/hcs_sched.sv
module hcs_sched #(
  parameter int N           = 8,
  parameter int LEN_W       = 11,
  parameter int RATE_W      = 12,
  parameter int RATIO_W     = 10,
  parameter int RATE_FLOOR  = 8,
  parameter int BURST       = 512,
  parameter int QUANT_SCALE = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pick_en,
  input  logic [N-1:0]           q_nonempty,
  input  logic [N*LEN_W-1:0]     q_len,
  input  logic [2*N-1:0]         cfg_prio,
  input  logic [N*RATE_W-1:0]    cfg_shape_rate,
  input  logic [N*RATE_W-1:0]    cfg_min_rate,
  input  logic [N*RATIO_W-1:0]   cfg_ratio,
  output logic                   grant_vld,
  output logic [$clog2(N)-1:0]   grant_cls
);
  import hcs_pkg::*;
  localparam int IDX_W = $clog2(N);

  logic [N-1:0] shp_ok, min_ok, shp_chg, min_chg, bad;
  logic [N-1:0] e_p1, e_p2, e_min, e_xs;
  logic         xs_serve, xs_hit, go, vld_d;
  logic [IDX_W-1:0] xs_win, win_d;
  hcs_lvl_e     lvl;
  logic         gv_q, gv_d;
  logic [IDX_W-1:0] gc_q, gc_d;

  function automatic logic [IDX_W-1:0] lowest(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_cls
    logic [1:0]        prio;
    logic              is_p1, is_p2, is_np, has_min, has_xs, base;
    logic [LEN_W-1:0]  len;

    assign prio    = cfg_prio[2*g +: 2];
    assign len     = q_len[g*LEN_W +: LEN_W];
    assign is_p1   = (prio == PRIO_CODE_P1);
    assign is_p2   = (prio == PRIO_CODE_P2);
    assign is_np   = !is_p1 && !is_p2;
    assign has_min = |cfg_min_rate[g*RATE_W +: RATE_W];
    assign has_xs  = |cfg_ratio[g*RATIO_W +: RATIO_W];
    assign bad[g]  = is_np && (has_min == has_xs);
    assign base    = q_nonempty[g] && shp_ok[g];

    assign e_p1[g]  = base && is_p1;
    assign e_p2[g]  = base && is_p2;
    assign e_min[g] = base && is_np && has_min && !has_xs && min_ok[g];
    assign e_xs[g]  = base && is_np && has_xs && !has_min;

    assign shp_chg[g] = go && (win_d == IDX_W'(g));
    assign min_chg[g] = shp_chg[g] && (lvl == LVL_MIN);

    hcs_bucket #(
      .RATE_W(RATE_W), .LEN_W(LEN_W), .RATE_FLOOR(RATE_FLOOR), .BURST(BURST)
    ) u_shaper (
      .clk(clk), .rst_n(rst_n),
      .rate(cfg_shape_rate[g*RATE_W +: RATE_W]),
      .charge(shp_chg[g]), .charge_len(len), .ok(shp_ok[g])
    );

    hcs_bucket #(
      .RATE_W(RATE_W), .LEN_W(LEN_W), .RATE_FLOOR(RATE_FLOOR), .BURST(BURST)
    ) u_minbkt (
      .clk(clk), .rst_n(rst_n),
      .rate(cfg_min_rate[g*RATE_W +: RATE_W]),
      .charge(min_chg[g]), .charge_len(len), .ok(min_ok[g])
    );
  end

  assign xs_serve = pick_en && !(|e_p1) && !(|e_p2) && !(|e_min) && (|e_xs);

  hcs_dwrr #(
    .N(N), .LEN_W(LEN_W), .RATIO_W(RATIO_W), .QUANT_SCALE(QUANT_SCALE)
  ) u_dwrr (
    .clk(clk), .rst_n(rst_n),
    .elig(e_xs), .nonempty(q_nonempty),
    .lens_flat(q_len), .ratio_flat(cfg_ratio),
    .serve(xs_serve), .hit(xs_hit), .win(xs_win)
  );

  always_comb begin
    lvl   = LVL_XS;
    win_d = xs_win;
    vld_d = xs_hit && (|e_xs);
    if (|e_p1) begin
      lvl = LVL_P1;  win_d = lowest(e_p1);  vld_d = 1'b1;
    end else if (|e_p2) begin
      lvl = LVL_P2;  win_d = lowest(e_p2);  vld_d = 1'b1;
    end else if (|e_min) begin
      lvl = LVL_MIN; win_d = lowest(e_min); vld_d = 1'b1;
    end
  end

  assign go = pick_en && vld_d;

  always_comb begin
    gv_d = go;
    gc_d = go ? win_d : gc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv_q <= 1'b0;
      gc_q <= '0;
    end else begin
      gv_q <= gv_d;
      gc_q <= gc_d;
    end
  end

  assign grant_vld = gv_q;
  assign grant_cls = gc_q;

  // Observation registers for the checks below.
  logic         p1_any_q;
  logic [N-1:0] p1_vec_q, bad_q, shp_ok_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_any_q <= 1'b0;
      p1_vec_q <= '0;
      bad_q    <= '0;
      shp_ok_q <= '0;
    end else begin
      p1_any_q <= pick_en && (|e_p1);
      p1_vec_q <= e_p1;
      bad_q    <= bad;
      shp_ok_q <= shp_ok;
    end
  end

  a_r1_grant_needs_pick: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> $past(pick_en));

  a_r2_p1_first: assert property (@(posedge clk) disable iff (!rst_n)
    p1_any_q |-> (grant_vld && p1_vec_q[grant_cls]));

  a_r5_shaper_gates: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> shp_ok_q[grant_cls]);

  a_r10_illegal_never: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> !bad_q[grant_cls]);
endmodule

// File: tb/hcs_sched_test.sv
module hcs_sched_test;
  localparam int N = 8, LEN_W = 11, RATE_W = 12, RATIO_W = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic pick_en;
  logic [N-1:0]         q_nonempty;
  logic [N*LEN_W-1:0]   q_len;
  logic [2*N-1:0]       cfg_prio;
  logic [N*RATE_W-1:0]  cfg_shape_rate, cfg_min_rate;
  logic [N*RATIO_W-1:0] cfg_ratio;
  logic                 grant_vld;
  logic [2:0]           grant_cls;

  int total = 0, bad = 0;
  int cnt [N];
  int gsum;

  always #2.5 clk = ~clk;

  hcs_sched uut (
    .clk(clk), .rst_n(rst_n), .pick_en(pick_en),
    .q_nonempty(q_nonempty), .q_len(q_len), .cfg_prio(cfg_prio),
    .cfg_shape_rate(cfg_shape_rate), .cfg_min_rate(cfg_min_rate),
    .cfg_ratio(cfg_ratio), .grant_vld(grant_vld), .grant_cls(grant_cls)
  );

  always @(negedge clk) begin
    if (rst_n && grant_vld) begin
      cnt[grant_cls] = cnt[grant_cls] + 1;
      gsum = gsum + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_cfg();
    q_nonempty = '0;
    cfg_prio = '0; cfg_shape_rate = '0; cfg_min_rate = '0; cfg_ratio = '0;
    for (int i = 0; i < N; i++) q_len[i*LEN_W +: LEN_W] = 11'd64;
  endtask

  task automatic set_cls(input int i, input logic [1:0] pr, input int shp,
                         input int mn, input int ra);
    cfg_prio[2*i +: 2]              = pr;
    cfg_shape_rate[i*RATE_W +: RATE_W] = RATE_W'(shp);
    cfg_min_rate[i*RATE_W +: RATE_W]   = RATE_W'(mn);
    cfg_ratio[i*RATIO_W +: RATIO_W]    = RATIO_W'(ra);
    q_nonempty[i] = 1'b1;
  endtask

  // Reset with the config in place; picks start at the first edge after release.
  task automatic run(input int idle, input int picks);
    pick_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) cnt[i] = 0;
    gsum = 0;
    pick_en = (idle == 0);
    rst_n = 1'b1;
    if (idle > 0) begin
      repeat (idle) @(negedge clk);
      pick_en = 1'b1;
    end
    repeat (picks) @(negedge clk);
    pick_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_cfg();
    set_cls(0, 2'b01, 4000, 0, 0);
    pick_en = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(grant_vld == 1'b0, "R1 grant low in reset", grant_vld, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(grant_vld == 1'b0, "R1 no grant without pick", grant_vld, 0);
    run(0, 10);
    chk(cnt[0] == 10, "R1 one grant per pick", cnt[0], 10);
  endtask

  task automatic t_order();
    clear_cfg();
    set_cls(0, 2'b00, 4000, 0, 1);
    set_cls(1, 2'b00, 4000, 4000, 0);
    set_cls(2, 2'b10, 4000, 0, 0);
    set_cls(3, 2'b01, 4000, 0, 0);
    run(0, 10);
    chk(cnt[3] == 10, "R2 R4 priority-1 served first", cnt[3], 10);
    q_nonempty[3] = 1'b0;
    run(0, 10);
    chk(cnt[2] == 10, "R2 R4 priority-2 next", cnt[2], 10);
    q_nonempty[2] = 1'b0;
    run(0, 10);
    chk(cnt[1] == 10, "R2 R4 minimum level next", cnt[1], 10);
    q_nonempty[1] = 1'b0;
    run(0, 10);
    chk(cnt[0] == 10, "R2 R4 excess level last", cnt[0], 10);
  endtask

  task automatic t_lowest();
    clear_cfg();
    set_cls(6, 2'b01, 4000, 0, 0);
    set_cls(4, 2'b01, 4000, 0, 0);
    run(0, 10);
    chk(cnt[4] == 10, "R3 lowest index wins", cnt[4], 10);
  endtask

  task automatic t_shaper();
    clear_cfg();
    set_cls(0, 2'b01, 8, 0, 0);
    set_cls(1, 2'b00, 100, 0, 1);
    run(0, 80);
    chk(cnt[0] == 10, "R5 shaped priority class rate", cnt[0], 10);
    chk(cnt[1] == 70, "R5 excess fills shaped gaps", cnt[1], 70);
    clear_cfg();
    set_cls(5, 2'b00, 8, 0, 1);
    run(0, 80);
    chk(cnt[5] == 10, "R5 shaper gates excess level", cnt[5], 10);
  endtask

  task automatic t_floor();
    clear_cfg();
    set_cls(0, 2'b01, 3, 0, 0);
    set_cls(1, 2'b00, 100, 0, 1);
    run(0, 80);
    chk(cnt[0] == 10, "R6 rate below floor acts as 8", cnt[0], 10);
  endtask

  task automatic t_burst();
    clear_cfg();
    set_cls(0, 2'b01, 8, 0, 0);
    run(100, 11);
    chk(cnt[0] == 10, "R7 burst capped at 512", cnt[0], 10);
  endtask

  task automatic t_min();
    clear_cfg();
    set_cls(1, 2'b00, 100, 8, 0);
    set_cls(6, 2'b00, 100, 0, 1);
    run(0, 80);
    chk(cnt[1] == 10, "R8 minimum bucket limits level", cnt[1], 10);
    chk(cnt[6] == 70, "R8 excess takes the rest", cnt[6], 70);
  endtask

  task automatic t_dwrr();
    clear_cfg();
    set_cls(2, 2'b00, 100, 0, 1);
    set_cls(5, 2'b00, 100, 0, 3);
    run(0, 40);
    chk(cnt[2] == 10, "R9 ratio 1 share", cnt[2], 10);
    chk(cnt[5] == 30, "R9 ratio 3 share", cnt[5], 30);
  endtask

  task automatic t_illegal();
    clear_cfg();
    set_cls(3, 2'b00, 4000, 100, 5);
    set_cls(0, 2'b00, 4000, 0, 0);
    run(0, 20);
    chk(gsum == 0, "R10 illegal classes never granted", gsum, 0);
    set_cls(7, 2'b00, 4000, 0, 2);
    run(0, 20);
    chk(cnt[7] == 20, "R10 legal class still served", cnt[7], 20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pick_en = 1'b0;
    gsum = 0;
    for (int i = 0; i < N; i++) cnt[i] = 0;
    clear_cfg();
    t_reset();
    t_order();
    t_lowest();
    t_shaper();
    t_floor();
    t_burst();
    t_min();
    t_dwrr();
    t_illegal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule